// File: doc/BRIEF.md
# Data Memory Address Unit with Pointer Indirection

This block sits between an 8-bit microcontroller core and its data RAM. For every register-file access it turns the 5-bit file field of the current instruction into an 8-bit data address. It then drives the address, write data, write strobe and read strobe to an external RAM of up to 256 bytes. A nonzero file field is a direct access: the three upper bits of the pointer register are placed above the file field as a bank number. A zero file field is an indirect access, and the whole 8-bit pointer register becomes the address.

The pointer register lives inside the block. Any access whose resolved address has low five bits equal to 4 reads or writes it. A resolved address with low five bits equal to 0 names the indirection slot itself. Reading it returns zero and writing it does nothing. Other resolved addresses with low five bits from 1 to 7 are special registers kept elsewhere. The block flags them on `sfr_hit_o` and never strobes the RAM for them. A build parameter selects synchronous RAM, where read data returns one clock after the read strobe, or asynchronous RAM, where it returns in the same cycle.

Top module: `data_addr_unit`

## Requirements
- R1: With a nonzero file field, `ram_addr_o` equals {pointer[7:5], file_i[4:0]} in the same cycle.
- R2: With a zero file field, `ram_addr_o` equals the full 8-bit pointer register.
- R3: A read whose resolved address has low five bits 00000 returns 00h with `rd_valid_o` set and `ram_oe_o` low.
- R4: A write whose resolved address has low five bits 00000 leaves `ram_we_o` low and the pointer unchanged.
- R5: A resolved address with low five bits 1, 2, 3, 5, 6 or 7 raises `sfr_hit_o` during the request, keeps both RAM strobes low, and a read of it returns 00h.
- R6: A resolved address with low five bits 00100 selects the pointer: a write loads `wr_data_i` at the clock edge, and a read returns the pointer value.
- R7: The pointer register is 00h after `rst_ni` is asserted low.
- R8: A write to a resolved address with low five bits 8 or higher raises `ram_we_o` in the same cycle, with `ram_wdata_o` equal to `wr_data_i`. `ram_we_o` is never high otherwise.
- R9: With RAM_SYNC=1, `ram_oe_o` rises with the address in the request cycle, and `rd_valid_o` and `rd_data_o` (from `ram_rdata_i`) follow one clock later.
- R10: With RAM_SYNC=0, `rd_valid_o` and `rd_data_o` (taken from `ram_rdata_i`) appear in the request cycle.
- R11: When `rd_req_i` and `wr_req_i` are both high, the write is performed and the read is dropped: `ram_oe_o` is low and `rd_valid_o` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| file_i | input | 5 | File field of the current instruction |
| rd_req_i | input | 1 | Read request this cycle |
| wr_req_i | input | 1 | Write request this cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, qualified by rd_valid_o |
| rd_valid_o | output | 1 | Read data valid |
| sfr_hit_o | output | 1 | Request targets a special register held outside |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_oe_o | output | 1 | RAM read strobe |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
The bench reads back, indirectly, every one of the 256 pointer values. A design that mixes up the five-bit slot decode would return RAM data for the null slot or for the special registers. It would also fail to return the pointer itself from slot 4 in every bank. A direct sweep over all eight banks catches bank bits taken from the wrong pointer bits. Targeted cases cover self-writes through the null slot, which a faulty design would let corrupt the pointer or strobe the RAM, and pointer loads made through indirection. They also cover a read and a write requested together, where a wrong design would raise both strobes or report a phantom read. Both RAM timing variants run side by side, so an off-by-one in the read return shows up on either instance.

// File: rtl/dau_pkg.sv
package dau_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_NULL = 2'd2,
    TGT_SFR  = 2'd3
  } tgt_e;
endpackage

// File: rtl/dau_addr_gen.sv
module dau_addr_gen
  import dau_pkg::*;
#(
  parameter int AW       = 8,
  parameter int FILE_W   = 5,
  parameter int SFR_TOP  = 8,
  parameter int PTR_FILE = 4
) (
  input  logic [FILE_W-1:0] file_i,
  input  logic [AW-1:0]     ptr_i,
  output logic [AW-1:0]     addr_o,
  output tgt_e              tgt_o
);
  localparam int BANK_W = AW - FILE_W;
  localparam logic [FILE_W-1:0] SFR_LIM = FILE_W'(SFR_TOP);
  localparam logic [FILE_W-1:0] PTR_SLOT = FILE_W'(PTR_FILE);

  logic [FILE_W-1:0] slot;

  always_comb begin
    if (file_i == '0) addr_o = ptr_i;
    else              addr_o = {ptr_i[AW-1 -: BANK_W], file_i};
  end

  assign slot = addr_o[FILE_W-1:0];

  always_comb begin
    if (slot == '0)            tgt_o = TGT_NULL;
    else if (slot == PTR_SLOT) tgt_o = TGT_PTR;
    else if (slot < SFR_LIM)   tgt_o = TGT_SFR;
    else                       tgt_o = TGT_RAM;
  end
endmodule

// File: rtl/dau_ptr_reg.sv
module dau_ptr_reg #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dau_rd_stage.sv
module dau_rd_stage
  import dau_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  tgt_e          tgt_i,
  input  logic [AW-1:0] ptr_i,
  output logic          valid_o,
  output tgt_e          tgt_o,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tgt_o   <= TGT_RAM;
      ptr_o   <= '0;
    end else begin
      valid_o <= go_i;
      if (go_i) begin
        tgt_o <= tgt_i;
        ptr_o <= ptr_i;
      end
    end
  end
endmodule

// File: rtl/data_addr_unit.sv
module data_addr_unit
  import dau_pkg::*;
#(
  parameter int AW       = 8,
  parameter int FILE_W   = 5,
  parameter int SFR_TOP  = 8,
  parameter int PTR_FILE = 4,
  parameter bit RAM_SYNC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILE_W-1:0] file_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [AW-1:0]     wr_data_i,
  output logic [AW-1:0]     rd_data_o,
  output logic              rd_valid_o,
  output logic              sfr_hit_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [AW-1:0]     ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_oe_o,
  input  logic [AW-1:0]     ram_rdata_i
);
  logic [AW-1:0] ptr_q;
  tgt_e          tgt;
  logic          rd_go;
  logic          ptr_load;
  tgt_e          ret_tgt;
  logic [AW-1:0] ret_ptr;

  dau_addr_gen #(
    .AW(AW), .FILE_W(FILE_W), .SFR_TOP(SFR_TOP), .PTR_FILE(PTR_FILE)
  ) i_addr_gen (
    .file_i (file_i),
    .ptr_i  (ptr_q),
    .addr_o (ram_addr_o),
    .tgt_o  (tgt)
  );

  // write wins over a simultaneous read
  assign rd_go    = rd_req_i & ~wr_req_i;
  assign ptr_load = wr_req_i & (tgt == TGT_PTR);

  dau_ptr_reg #(.AW(AW)) i_ptr_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ptr_load),
    .d_i    (wr_data_i),
    .q_o    (ptr_q)
  );

  assign ram_wdata_o = wr_data_i;
  assign ram_we_o    = wr_req_i & (tgt == TGT_RAM);
  assign ram_oe_o    = rd_go & (tgt == TGT_RAM);
  assign sfr_hit_o   = (rd_req_i | wr_req_i) & (tgt == TGT_SFR);

  generate
    if (RAM_SYNC) begin : g_sync
      dau_rd_stage #(.AW(AW)) i_rd_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .go_i    (rd_go),
        .tgt_i   (tgt),
        .ptr_i   (ptr_q),
        .valid_o (rd_valid_o),
        .tgt_o   (ret_tgt),
        .ptr_o   (ret_ptr)
      );
    end else begin : g_async
      assign rd_valid_o = rd_go;
      assign ret_tgt    = tgt;
      assign ret_ptr    = ptr_q;
    end
  endgenerate

  always_comb begin
    unique case (ret_tgt)
      TGT_RAM: rd_data_o = ram_rdata_i;
      TGT_PTR: rd_data_o = ret_ptr;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/data_addr_unit_chk.sv
module data_addr_unit_chk #(
  parameter int AW       = 8,
  parameter int FILE_W   = 5,
  parameter int SFR_TOP  = 8,
  parameter bit RAM_SYNC = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FILE_W-1:0] file_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic              rd_valid_o,
  input logic [AW-1:0]     ram_addr_o,
  input logic              ram_we_o,
  input logic              ram_oe_o,
  input logic [AW-1:0]     ptr_q
);
  assert_direct_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_req_i || wr_req_i) && file_i != '0) |->
      ram_addr_o == {ptr_q[AW-1:FILE_W], file_i});

  assert_indirect_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_req_i || wr_req_i) && file_i == '0) |-> ram_addr_o == ptr_q);

  assert_self_write_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && file_i == '0 && ptr_q[FILE_W-1:0] == '0) |=> $stable(ptr_q));

  assert_self_write_no_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && file_i == '0 && ptr_q[FILE_W-1:0] == '0) |-> !ram_we_o);

  assert_we_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (wr_req_i && ram_addr_o[FILE_W-1:0] >= FILE_W'(SFR_TOP)));

  assert_collide_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i) |-> !ram_oe_o);

  generate
    if (RAM_SYNC) begin : g_sync
      assert_sync_return_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_oe_o |=> rd_valid_o);
    end else begin : g_async
      assert_async_return_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_oe_o |-> rd_valid_o);
    end
  endgenerate
endmodule

bind data_addr_unit data_addr_unit_chk #(
  .AW(AW), .FILE_W(FILE_W), .SFR_TOP(SFR_TOP), .RAM_SYNC(RAM_SYNC)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .file_i     (file_i),
  .rd_req_i   (rd_req_i),
  .wr_req_i   (wr_req_i),
  .rd_valid_o (rd_valid_o),
  .ram_addr_o (ram_addr_o),
  .ram_we_o   (ram_we_o),
  .ram_oe_o   (ram_oe_o),
  .ptr_q      (ptr_q)
);

// File: tb/test_data_addr_unit.sv
`timescale 1ns/1ps
module test_data_addr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] file = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wd = '0;

  logic [7:0] rdata_s, rdata_a, ramrd_s, ramrd_a, addr_s, addr_a, wdat_s, wdat_a;
  logic       valid_s, valid_a, hit_s, hit_a, we_s, we_a, oe_s, oe_a;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  data_addr_unit #(.RAM_SYNC(1'b1)) i_data_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .file_i(file), .rd_req_i(rd), .wr_req_i(wr),
    .wr_data_i(wd), .rd_data_o(rdata_s), .rd_valid_o(valid_s), .sfr_hit_o(hit_s),
    .ram_addr_o(addr_s), .ram_wdata_o(wdat_s), .ram_we_o(we_s), .ram_oe_o(oe_s),
    .ram_rdata_i(ramrd_s));

  data_addr_unit #(.RAM_SYNC(1'b0)) i_data_addr_unit_async (
    .clk_i(clk), .rst_ni(rst_n), .file_i(file), .rd_req_i(rd), .wr_req_i(wr),
    .wr_data_i(wd), .rd_data_o(rdata_a), .rd_valid_o(valid_a), .sfr_hit_o(hit_a),
    .ram_addr_o(addr_a), .ram_wdata_o(wdat_a), .ram_we_o(we_a), .ram_oe_o(oe_a),
    .ram_rdata_i(ramrd_a));

  logic [7:0] mem_s [256];
  logic [7:0] mem_a [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_s[i] = '0;
      mem_a[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (we_s) mem_s[addr_s] <= wdat_s;
    if (oe_s) ramrd_s <= mem_s[addr_s];
    if (we_a) mem_a[addr_a] <= wdat_a;
  end
  assign ramrd_a = mem_a[addr_a];

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write request; samples strobes in the request cycle
  task automatic do_wr(input logic [4:0] f, input logic [7:0] d,
                       output logic [7:0] a_s, output logic [7:0] a_a,
                       output logic w_s, output logic w_a, output logic h);
    @(negedge clk);
    file = f; wd = d; wr = 1'b1; rd = 1'b0;
    #1;
    a_s = addr_s; a_a = addr_a; w_s = we_s; w_a = we_a; h = hit_s;
    @(posedge clk);
    #1;
    wr = 1'b0;
  endtask

  // read request; async result in cycle, sync result after the edge
  task automatic do_rd(input logic [4:0] f,
                       output logic [7:0] d_s, output logic [7:0] d_a,
                       output logic v_s, output logic v_a,
                       output logic [7:0] a_s, output logic o_s, output logic o_a,
                       output logic h);
    @(negedge clk);
    file = f; rd = 1'b1; wr = 1'b0;
    #1;
    d_a = rdata_a; v_a = valid_a; a_s = addr_s; o_s = oe_s; o_a = oe_a; h = hit_s;
    @(posedge clk);
    #1;
    d_s = rdata_s; v_s = valid_s;
    rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic [7:0] x1, x2;
    logic w1, w2, h;
    do_wr(5'd4, p, x1, x2, w1, w2, h);
  endtask

  initial begin : watchdog
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] a_s, a_a, d_s, d_a;
    logic w_s, w_a, h, v_s, v_a, o_s, o_a;

    repeat (3) @(posedge clk);
    #1;
    chk("R7 we idle in reset", we_s | we_a, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: pointer reads 00h after reset
    do_rd(5'd4, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R7 sync ptr", d_s, 0);
    chk("R7 async ptr", d_a, 0);
    chk("R9 sync valid", v_s, 1);
    chk("R10 async valid", v_a, 1);

    // direct sweep over all banks, R1 R8 R9 R10
    for (int b = 0; b < 8; b++) begin
      set_ptr(8'(b << 5));
      for (int f = 8; f < 32; f++) begin
        logic [7:0] ea;
        ea = 8'((b << 5) | f);
        do_wr(5'(f), pat(ea), a_s, a_a, w_s, w_a, h);
        chk("R1 direct addr sync", a_s, ea);
        chk("R1 direct addr async", a_a, ea);
        chk("R8 we sync", w_s, 1);
        chk("R8 we async", w_a, 1);
        do_rd(5'(f), d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
        chk("R9 sync data", d_s, pat(ea));
        chk("R9 sync oe", o_s, 1);
        chk("R10 async data", d_a, pat(ea));
        chk("R10 async valid", v_a, 1);
      end
    end

    // indirect sweep over every pointer value, R2 R3 R5 R6
    for (int p = 0; p < 256; p++) begin
      int lo;
      int exp_d;
      int exp_oe;
      int exp_h;
      lo = p & 31;
      set_ptr(8'(p));
      do_rd(5'd0, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
      exp_oe = (lo >= 8) ? 1 : 0;
      exp_h  = (lo != 0 && lo != 4 && lo < 8) ? 1 : 0;
      if (lo == 0)      exp_d = 0;
      else if (lo == 4) exp_d = p;
      else if (lo < 8)  exp_d = 0;
      else              exp_d = pat(8'(p));
      chk("R2 indirect addr", a_s, p);
      if (lo == 0) begin
        chk("R3 null read sync", d_s, 0);
        chk("R3 null read async", d_a, 0);
        chk("R3 null valid", v_s & v_a, 1);
        chk("R3 null oe", o_s | o_a, 0);
      end else if (lo == 4) begin
        chk("R6 ptr read sync", d_s, exp_d);
        chk("R6 ptr read async", d_a, exp_d);
      end else if (lo < 8) begin
        chk("R5 sfr read sync", d_s, 0);
        chk("R5 sfr read async", d_a, 0);
        chk("R5 sfr hit", h, exp_h);
        chk("R5 sfr oe", o_s | o_a, 0);
      end else begin
        chk("R2 indirect data sync", d_s, exp_d);
        chk("R2 indirect data async", d_a, exp_d);
        chk("R9 indirect oe", o_s, exp_oe);
        chk("R5 no hit on ram", h, 0);
      end
    end

    // R4: self write through the null slot
    set_ptr(8'h40);
    do_wr(5'd0, 8'h77, a_s, a_a, w_s, w_a, h);
    chk("R4 self write we", w_s | w_a, 0);
    do_rd(5'd4, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R4 ptr kept sync", d_s, 8'h40);
    chk("R4 ptr kept async", d_a, 8'h40);
    set_ptr(8'h00);
    do_wr(5'd0, 8'h5E, a_s, a_a, w_s, w_a, h);
    chk("R4 self write we bank0", w_s | w_a, 0);
    do_rd(5'd4, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R4 ptr kept bank0", d_s, 0);

    // R6: pointer loaded through indirection
    set_ptr(8'hE4);
    do_wr(5'd0, 8'h3C, a_s, a_a, w_s, w_a, h);
    chk("R6 ptr write no we", w_s | w_a, 0);
    do_rd(5'd4, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R6 ptr indirect load sync", d_s, 8'h3C);
    chk("R6 ptr indirect load async", d_a, 8'h3C);

    // R5: special register write
    set_ptr(8'h20);
    do_wr(5'd2, 8'h11, a_s, a_a, w_s, w_a, h);
    chk("R5 sfr write we", w_s | w_a, 0);
    chk("R5 sfr write hit", h, 1);
    do_rd(5'd9, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R5 neighbour untouched", d_s, pat(8'h29));

    // R11: read and write together
    set_ptr(8'h60);
    @(negedge clk);
    file = 5'd9; wd = 8'hC3; rd = 1'b1; wr = 1'b1;
    #1;
    chk("R11 oe low", oe_s | oe_a, 0);
    chk("R11 we high", we_s & we_a, 1);
    chk("R11 async no valid", valid_a, 0);
    @(posedge clk);
    #1;
    chk("R11 sync no valid", valid_s, 0);
    rd = 1'b0; wr = 1'b0;
    do_rd(5'd9, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R11 write landed sync", d_s, 8'hC3);
    chk("R11 write landed async", d_a, 8'hC3);
    chk("R1 addr 0x69", a_s, 8'h69);

    // R9: valid falls when idle
    @(negedge clk);
    @(posedge clk);
    #1;
    chk("R9 valid drops", valid_s, 0);

    // R7: reset brings pointer back
    set_ptr(8'hAB);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_rd(5'd4, d_s, d_a, v_s, v_a, a_s, o_s, o_a, h);
    chk("R7 ptr after reset", d_s, 0);
    chk("R7 ptr after reset async", d_a, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule